// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an external asynchronous static RAM of 128K bytes. The host asks for one byte at a time. It presents a request with an address, a read/write select and write data, and holds it until the controller shows ready. The controller then plays out the memory waveform. It drives the two chip selects (one active low, one active high), the active-low output and write strobes, the address, and a split data bus with output, enable and input. For a read, it returns the captured byte together with a one-cycle valid strobe.

Each phase length is derived at elaboration from nanosecond parameters and the clock period, using ceiling division and a floor of one cycle. The phases are the write strobe width, the data setup, the write cycle, the read access time and the output-enable-to-high-impedance time. All memory-side strobes come straight from flops, so they do not glitch. Output enable stays high for every write. The data driver is only on inside the write strobe and never in its first cycle. A write that follows a read waits a turnaround period first.

Top module: `sram_ctrl`

## Requirements
- R1: While rst_ni is low and right after it: mem_ce1_n_o=1, mem_ce2_o=0, mem_oe_n_o=1, mem_we_n_o=1, mem_dq_oe_o=0, rvalid_o=0 and ready_o=1.
- R2: A byte written at an address is returned unchanged by a later read of that address, including addresses 0x00000 and 0x1FFFF and data 0x00 and 0xFF.
- R3: mem_we_n_o is low for exactly max(ceil(T_WP/P), ceil(T_SD/P)+1) consecutive cycles per write, which is 3 with the defaults (P=5 ns). While it is low, the memory is selected (ce1_n=0, ce2=1) and mem_oe_n_o=1.
- R4: mem_dq_oe_o is 1 only in a cycle where mem_we_n_o is low and was already low in the previous cycle. It is 0 in the cycle where mem_we_n_o rises, and it is never 1 while mem_oe_n_o is 0.
- R5: mem_addr_o is constant while mem_we_n_o stays low. mem_dq_o equals the accepted write data whenever it is driven.
- R6: A read holds select, mem_oe_n_o=0 and mem_we_n_o=1 with a stable address for ceil(T_ACC/P) cycles, which is 3 with the defaults. It then samples mem_dq_i and returns that byte on rdata_o.
- R7: rvalid_o is high for exactly one cycle per accepted read and never for a write.
- R8: A request is accepted only on a clock edge where ready_o is 1. After acceptance, ready_o stays low for 4 cycles for a read and 5 cycles for a write (defaults). A request held while ready_o is low has no effect.
- R9: A write accepted after a read first waits ceil(T_HZ/P) turnaround cycles, which is 2 with the defaults. With back-to-back requests, at least 5 cycles with mem_oe_n_o=1 pass before mem_we_n_o falls. That write keeps ready_o low for 7 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 17 | Host byte address |
| wdata_i | input | 8 | Host write data |
| ready_o | output | 1 | Controller idle, request accepted on this edge |
| rdata_o | output | 8 | Captured read data |
| rvalid_o | output | 1 | One-cycle read data strobe |
| mem_ce1_n_o | output | 1 | Memory select, active low |
| mem_ce2_o | output | 1 | Memory select, active high |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_we_n_o | output | 1 | Memory write strobe, active low |
| mem_addr_o | output | 17 | Memory address |
| mem_dq_o | output | 8 | Data bus outgoing value |
| mem_dq_oe_o | output | 1 | Data bus driver enable |
| mem_dq_i | input | 8 | Data bus incoming value |

## Verification
The bound checker watches the bus rules on every cycle. These are: the select and output-enable state during the write strobe, the driver window relative to the strobe, address and data stability while the strobe is low, and the single-cycle read strobe. Some behaviours depend on the memory's contents or on history across transactions, so only the bench scenarios can show them. These are the stored value after a write, the exact strobe width, the sampling point of the read relative to the access time, the busy durations, the ignored held request and the turnaround after a read. The bench does this with a memory model that returns garbage until the access time has elapsed.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TURN, ST_WADDR, ST_WPULSE, ST_WEND, ST_RACC, ST_RDONE
  } ctrl_state_e;

  // ceil(ns/per), at least one cycle
  function automatic int unsigned cyc_ceil(int unsigned ns, int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int unsigned CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned N_WE   = 3,
  parameter int unsigned N_WEND = 1,
  parameter int unsigned N_ACC  = 3,
  parameter int unsigned N_TURN = 2,
  parameter int unsigned CW     = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic          wr_i,
  input  logic          expired_i,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output ctrl_state_e   st_o,
  output ctrl_state_e   nxt_o
);
  localparam logic [CW-1:0] L_WE   = CW'(N_WE - 1);
  localparam logic [CW-1:0] L_WEND = CW'(N_WEND - 1);
  localparam logic [CW-1:0] L_ACC  = CW'(N_ACC - 1);
  localparam logic [CW-1:0] L_TURN = CW'(N_TURN - 1);

  ctrl_state_e st_q, nxt;
  logic        last_rd_q;

  always_comb begin
    nxt        = st_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (st_q)
      ST_IDLE: if (fire_i) begin
        if (!wr_i) begin
          nxt = ST_RACC; load_o = 1'b1; load_val_o = L_ACC;
        end else if (last_rd_q) begin
          nxt = ST_TURN; load_o = 1'b1; load_val_o = L_TURN;
        end else begin
          nxt = ST_WADDR;
        end
      end
      ST_TURN:   if (expired_i) nxt = ST_WADDR;
      ST_WADDR:  begin nxt = ST_WPULSE; load_o = 1'b1; load_val_o = L_WE; end
      ST_WPULSE: if (expired_i) begin
        nxt = ST_WEND; load_o = 1'b1; load_val_o = L_WEND;
      end
      ST_WEND:   if (expired_i) nxt = ST_IDLE;
      ST_RACC:   if (expired_i) nxt = ST_RDONE;
      ST_RDONE:  nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      last_rd_q <= 1'b0;
    end else begin
      st_q <= nxt;
      if (nxt == ST_RACC)       last_rd_q <= 1'b1;
      else if (nxt == ST_WADDR) last_rd_q <= 1'b0;
    end
  end

  assign st_o  = st_q;
  assign nxt_o = nxt;
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W       = 17,
  parameter int unsigned DATA_W       = 8,
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter int unsigned T_ACC_NS     = 15,
  parameter int unsigned T_WP_NS      = 12,
  parameter int unsigned T_SD_NS      = 8,
  parameter int unsigned T_WC_NS      = 15,
  parameter int unsigned T_HZ_NS      = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              mem_ce1_n_o,
  output logic              mem_ce2_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int unsigned N_ACC  = cyc_ceil(T_ACC_NS, CLK_PERIOD_NS);
  localparam int unsigned N_WE   = umax(cyc_ceil(T_WP_NS, CLK_PERIOD_NS),
                                        cyc_ceil(T_SD_NS, CLK_PERIOD_NS) + 1);
  localparam int unsigned N_WC   = cyc_ceil(T_WC_NS, CLK_PERIOD_NS);
  localparam int unsigned N_WEND = (N_WC > N_WE + 1) ? (N_WC - N_WE - 1) : 1;
  localparam int unsigned N_TURN = cyc_ceil(T_HZ_NS, CLK_PERIOD_NS);
  localparam int unsigned N_MAX  = umax(umax(N_ACC, N_WE), umax(N_WEND, N_TURN));
  localparam int unsigned CW     = $clog2(N_MAX + 1);

  ctrl_state_e   st, nxt;
  logic          fire, tmr_load, tmr_exp, sel_nxt;
  logic [CW-1:0] tmr_val;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic          rvalid_q;
  logic          ce1_n_q, ce2_q, oe_n_q, we_n_q, dq_oe_q;

  assign ready_o = (st == ST_IDLE);
  assign fire    = req_i & ready_o;

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .expired_o  (tmr_exp)
  );

  sram_ctrl_fsm #(
    .N_WE(N_WE), .N_WEND(N_WEND), .N_ACC(N_ACC), .N_TURN(N_TURN), .CW(CW)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .wr_i       (wr_i),
    .expired_i  (tmr_exp),
    .load_o     (tmr_load),
    .load_val_o (tmr_val),
    .st_o       (st),
    .nxt_o      (nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (fire) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  // strobes from flops, decoded from next state
  assign sel_nxt = (nxt == ST_WADDR) || (nxt == ST_WPULSE) ||
                   (nxt == ST_WEND)  || (nxt == ST_RACC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce1_n_q <= 1'b1;
      ce2_q   <= 1'b0;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
    end else begin
      ce1_n_q <= ~sel_nxt;
      ce2_q   <= sel_nxt;
      oe_n_q  <= ~(nxt == ST_RACC);
      we_n_q  <= ~(nxt == ST_WPULSE);
      // drive only from the second strobe cycle; drop with the rising strobe
      dq_oe_q <= (nxt == ST_WPULSE) && (st == ST_WPULSE);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= (st == ST_RACC) && tmr_exp;
      if ((st == ST_RACC) && tmr_exp) rdata_q <= mem_dq_i;
    end
  end

  assign rdata_o     = rdata_q;
  assign rvalid_o    = rvalid_q;
  assign mem_ce1_n_o = ce1_n_q;
  assign mem_ce2_o   = ce2_q;
  assign mem_oe_n_o  = oe_n_q;
  assign mem_we_n_o  = we_n_q;
  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign mem_dq_oe_o = dq_oe_q;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              rvalid_o,
  input logic              mem_ce1_n_o,
  input logic              mem_ce2_o,
  input logic              mem_oe_n_o,
  input logic              mem_we_n_o,
  input logic              mem_dq_oe_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_dq_o
);
  assert_we_selected_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (!mem_ce1_n_o && mem_ce2_o && mem_oe_n_o));

  assert_drive_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> (!mem_we_n_o && !$past(mem_we_n_o)));

  assert_release_on_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> !mem_dq_oe_o);

  assert_no_contention_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_dq_oe_o && !mem_oe_n_o));

  assert_addr_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_n_o && !$past(mem_we_n_o)) |-> $stable(mem_addr_o));

  assert_data_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_dq_oe_o && $past(mem_dq_oe_o)) |-> $stable(mem_dq_o));

  assert_read_strobes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> (mem_we_n_o && !mem_ce1_n_o && mem_ce2_o));

  assert_rvalid_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);

  assert_busy_during_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_n_o || !mem_oe_n_o) |-> !ready_o);
endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ready_o     (ready_o),
  .rvalid_o    (rvalid_o),
  .mem_ce1_n_o (mem_ce1_n_o),
  .mem_ce2_o   (mem_ce2_o),
  .mem_oe_n_o  (mem_oe_n_o),
  .mem_we_n_o  (mem_we_n_o),
  .mem_dq_oe_o (mem_dq_oe_o),
  .mem_addr_o  (mem_addr_o),
  .mem_dq_o    (mem_dq_o)
);

// File: tb/sram_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_ctrl_tb_top;
  localparam int P_NS   = 5;
  localparam int N_ACC  = 3;  // ceil(15/5)
  localparam int N_WE   = 3;  // max(ceil(12/5), ceil(8/5)+1)
  localparam int N_TURN = 2;  // ceil(7/5)

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 1'b0, wr = 1'b0;
  logic [16:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic ready, rvalid, ce1_n, ce2, oe_n, we_n, dq_oe;
  logic [7:0]  rdata, dq_o, dq_i;
  logic [16:0] maddr;

  always #2.5 clk = ~clk;

  sram_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata), .rvalid_o(rvalid),
    .mem_ce1_n_o(ce1_n), .mem_ce2_o(ce2), .mem_oe_n_o(oe_n), .mem_we_n_o(we_n),
    .mem_addr_o(maddr), .mem_dq_o(dq_o), .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(bit ok, string rq, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  // memory model and reference
  logic [7:0] mem [int];
  logic [7:0] ref_mem [int];
  logic [7:0] exp_q [$];
  logic [7:0] exp_wdata = '0;
  int  rd_cnt = 0, wr_commits = 0, we_low = 0, oe_hi_run = 0, last_gap = 0;
  logic [17:0] prev_key = '0;
  bit  prev_we_n = 1, prev_rv = 0, pend_v = 0;
  logic [16:0] pend_a;
  logic [7:0]  pend_d;

  function automatic logic [7:0] mget(int a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction

  always @(negedge clk) if (rst_ni) begin
    bit sel, rd_en;
    sel   = !ce1_n && ce2;
    rd_en = sel && !oe_n && we_n;
    if ({rd_en, maddr} != prev_key) rd_cnt = 1; else rd_cnt++;
    prev_key = {rd_en, maddr};
    dq_i = (rd_en && rd_cnt >= N_ACC) ? mget(maddr) : ~mget(maddr);
    if (dq_oe && !oe_n) chk(0, "R4 contention", 1, 0);
    if (!we_n && prev_we_n && dq_oe) chk(0, "R4 first-cycle drive", 1, 0);
    if (dq_oe) chk(dq_o == exp_wdata, "R5 write data", dq_o, exp_wdata);
    if (sel && !we_n && dq_oe) begin pend_v = 1; pend_a = maddr; pend_d = dq_o; end
    if (we_n && pend_v) begin mem[pend_a] = pend_d; pend_v = 0; wr_commits++; end
    if (!oe_n) oe_hi_run = 0; else oe_hi_run++;
    if (!we_n && prev_we_n) last_gap = oe_hi_run - 1;
    if (!we_n) we_low++;
    else if (!prev_we_n) begin
      chk(we_low == N_WE, "R3 strobe width", we_low, N_WE);
      we_low = 0;
    end
    prev_we_n = we_n;
    // scoreboard monitor
    if (rvalid) begin
      if (prev_rv) chk(0, "R7 rvalid width", 2, 1);
      if (exp_q.size() == 0) chk(0, "R7 unexpected rvalid", 1, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rdata == e, "R6 read data", rdata, e);
      end
    end
    prev_rv = rvalid;
  end

  // driver: call at a negedge; returns at the negedge after acceptance
  task automatic issue(bit w, logic [16:0] a, logic [7:0] d);
    req = 1; wr = w; addr = a; wdata = d;
    while (!ready) @(negedge clk);
    if (w) begin
      ref_mem[a] = d;
      exp_wdata = d;
    end else exp_q.push_back(ref_mem.exists(a) ? ref_mem[a] : 8'h00);
    @(negedge clk);
    req = 0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (!ready) begin n++; @(negedge clk); end
  endtask

  int n, cw;

  initial begin
    repeat (3) @(negedge clk);
    chk(ce1_n == 1 && ce2 == 0, "R1 deselected", {ce1_n, ce2}, 2'b10);
    chk(oe_n == 1 && we_n == 1 && dq_oe == 0, "R1 strobes idle", {oe_n, we_n, dq_oe}, 3'b110);
    chk(ready == 1 && rvalid == 0, "R1 ready/rvalid", {ready, rvalid}, 2'b10);
    rst_ni = 1;
    @(negedge clk);
    chk(ce1_n == 1 && we_n == 1 && oe_n == 1 && ready == 1, "R1 after release", {ce1_n, we_n, oe_n, ready}, 4'hF);

    issue(1, 17'h00000, 8'hFF); busy_len(n);
    chk(n == 5, "R8 write busy", n, 5);
    issue(1, 17'h1FFFF, 8'h00); busy_len(n);
    issue(1, 17'h0ABCD, 8'h5C); busy_len(n);
    issue(0, 17'h00000, 8'h00); busy_len(n);
    chk(n == 4, "R8 read busy", n, 4);
    issue(0, 17'h1FFFF, 8'h00); busy_len(n);
    issue(0, 17'h0ABCD, 8'h00); busy_len(n);
    issue(0, 17'h01234, 8'h00); busy_len(n);   // R2 unwritten reads 0
    chk(mget(17'h00000) == 8'hFF, "R2 memory at 0x00000", mget(0), 8'hFF);
    chk(mget(17'h1FFFF) == 8'h00, "R2 memory at 0x1FFFF", mget(17'h1FFFF), 8'h00);

    // R9 back-to-back read then write
    issue(0, 17'h0ABCD, 8'h00);
    issue(1, 17'h00777, 8'hA6); busy_len(n);
    chk(n == 7, "R9 write-after-read busy", n, 7);
    chk(last_gap >= N_TURN + 3, "R9 oe-high gap before strobe", last_gap, N_TURN + 3);
    issue(1, 17'h00778, 8'h39); busy_len(n);
    chk(n == 5, "R9 write-after-write busy", n, 5);
    issue(0, 17'h00777, 8'h00); busy_len(n);
    issue(0, 17'h00778, 8'h00); busy_len(n);

    // R8 held request while busy is ignored
    issue(1, 17'h00100, 8'h22);
    cw = wr_commits;
    req = 1; wr = 1; addr = 17'h00100; wdata = 8'h33;
    @(negedge clk);
    chk(ready == 0, "R8 busy while held", ready, 0);
    @(negedge clk);
    req = 0;
    busy_len(n);
    repeat (3) @(negedge clk);
    chk(wr_commits == cw + 1, "R8 single write committed", wr_commits - cw, 1);
    issue(0, 17'h00100, 8'h00); busy_len(n);

    // R6/R7 read after read, pattern sweep
    for (int i = 0; i < 8; i++) begin
      issue(1, 17'(i * 4099), 8'(i * 37 + 1)); busy_len(n);
    end
    for (int i = 0; i < 8; i++) begin
      issue(0, 17'(i * 4099), 8'h00); busy_len(n);
    end
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 one rvalid per read", exp_q.size(), 0);
    chk(rvalid == 0, "R7 rvalid idle", rvalid, 0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * P_NS);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule